// File: doc/BRIEF.md
# Stack Word Push/Pop Sequencer

This block moves 16-bit words between the core and a byte-wide memory through a 16-bit stack pointer that it owns. A command is presented with a one-cycle start strobe. The command can push a word, pop a word, or perform a return that pops only when the zero flag is clear. The block then runs the byte accesses one per cycle. It steps the stack pointer with each access. When it finishes, it raises a single-cycle done pulse together with the popped word and the tick cost of the operation.

The memory has a one-cycle read latency: data for a read request made in one cycle is present on `mem_rdata` in the next cycle. The command encoding is: 2'b00 push, 2'b01 pop, 2'b10 return-if-not-zero, and 2'b11 reserved. When a return is taken, `pc_load` rises with `done`, and the caller then loads its program counter from `pop_word`. Instruction fetch and decode are left to the surrounding core.

Top module: `stack_seq`

## Requirements
- R1: A push writes the high byte at SP-1 in the first cycle after acceptance, then the low byte at SP-2 in the next cycle; the stack pointer ends at SP-2.
- R2: A pop reads address SP in the first cycle after acceptance and SP+1 in the next cycle; the word delivered with done has the first byte read as its low byte and the second as its high byte, and the stack pointer ends at SP+2.
- R3: The stack pointer wraps modulo 65536 in both directions (a pop from 0xFFFE reads 0xFFFE and 0xFFFF and ends at 0x0000; a push from 0x0000 writes 0xFFFF then 0xFFFE).
- R4: A return-if-not-zero with the zero flag set makes no memory access, leaves the stack pointer unchanged, keeps pc_load low, signals done in the first cycle after acceptance and reports a cost of 8.
- R5: A return-if-not-zero with the zero flag clear performs a full pop and raises pc_load for the done cycle with the popped word, reporting a cost of 20.
- R6: The reported cost is 12 for a pop and 16 for a push, valid in the done cycle.
- R7: done is high for exactly one cycle per accepted command: 3 cycles after acceptance for a push, 4 for a pop or a taken return.
- R8: While busy, start is ignored, and cmd, push_word and zero_flag changes have no effect on the command in flight; no memory request is issued while not busy.
- R9: After reset the stack pointer is 0xFFFE, and busy, done, pc_load, mem_rd and mem_wr are low.
- R10: A start with the reserved code 2'b11 is not accepted: busy stays low and no memory access follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Command strobe, taken only when idle |
| cmd | input | 2 | Command code (00 push, 01 pop, 10 return-if-not-zero, 11 reserved) |
| zero_flag | input | 1 | Zero flag for the conditional return |
| push_word | input | 16 | Word to push, latched at acceptance |
| busy | output | 1 | A command is in flight |
| done | output | 1 | One-cycle completion pulse |
| pc_load | output | 1 | Taken return; high with done |
| pop_word | output | 16 | Last popped word |
| cost_ticks | output | 5 | Tick cost of the last accepted command |
| sp_out | output | 16 | Current stack pointer |
| mem_rd | output | 1 | Byte read request |
| mem_wr | output | 1 | Byte write request |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Read byte, one cycle after mem_rd |

## Verification
The completion pulse and a fresh start strobe can share a cycle, because the done cycle still counts as busy. The bench holds start high across a whole command. During that command it also changes cmd and push_word. It then checks that the operation in flight used the latched values, that done stays a single pulse, and that no second command starts until start is seen in an idle cycle. A reference model with its own memory and pointer predicts every output in every cycle, and the bench compares the design against it.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [1:0] {
    CMD_PUSH  = 2'b00,
    CMD_POP   = 2'b01,
    CMD_RETNZ = 2'b10,
    CMD_RSVD  = 2'b11
  } stk_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_HI,
    ST_WR_LO,
    ST_RD_LO,
    ST_RD_HI,
    ST_TAIL,
    ST_FIN
  } stk_state_e;

  localparam int COST_PUSH     = 16;
  localparam int COST_POP      = 12;
  localparam int COST_RET_SKIP = 8;
  localparam int COST_RET_TAKE = 20;

  // tick cost of a command given the zero flag at acceptance
  function automatic int cost_of(input logic [1:0] c, input logic z);
    case (c)
      CMD_PUSH:  return COST_PUSH;
      CMD_POP:   return COST_POP;
      CMD_RETNZ: return z ? COST_RET_SKIP : COST_RET_TAKE;
      default:   return 0;
    endcase
  endfunction

  function automatic logic ret_taken(input logic [1:0] c, input logic z);
    return (c == CMD_RETNZ) && !z;
  endfunction

endpackage

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int COST_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        cmd,
  input  logic              zero_flag,
  output logic              accept,
  output logic              busy,
  output logic              step_dn,
  output logic              step_up,
  output logic              sel_hi,
  output logic              cap_lo,
  output logic              cap_hi,
  output logic              fin,
  output logic              pc_load,
  output logic [COST_W-1:0] cost_ticks
);

  stk_state_e st, st_nx;
  logic       take_q;

  assign accept  = (st == ST_IDLE) && start && (cmd != CMD_RSVD);
  assign busy    = (st != ST_IDLE);
  assign step_dn = (st == ST_WR_HI) || (st == ST_WR_LO);
  assign step_up = (st == ST_RD_LO) || (st == ST_RD_HI);
  assign sel_hi  = (st == ST_WR_HI);
  assign cap_lo  = (st == ST_RD_HI);
  assign cap_hi  = (st == ST_TAIL);
  assign fin     = (st == ST_FIN);
  assign pc_load = fin && take_q;

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE: begin
        if (accept) begin
          if (cmd == CMD_PUSH)                    st_nx = ST_WR_HI;
          else if (cmd == CMD_RETNZ && zero_flag) st_nx = ST_FIN;
          else                                    st_nx = ST_RD_LO;
        end
      end
      ST_WR_HI: st_nx = ST_WR_LO;
      ST_WR_LO: st_nx = ST_FIN;
      ST_RD_LO: st_nx = ST_RD_HI;
      ST_RD_HI: st_nx = ST_TAIL;
      ST_TAIL:  st_nx = ST_FIN;
      default:  st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      take_q     <= 1'b0;
      cost_ticks <= '0;
    end else begin
      st <= st_nx;
      if (accept) begin
        take_q     <= ret_taken(cmd, zero_flag);
        cost_ticks <= COST_W'(cost_of(cmd, zero_flag));
      end
    end
  end

endmodule

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter int          ADDR_W   = 16,
  parameter int unsigned RESET_SP = 'hFFFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_dn,
  input  logic              step_up,
  output logic [ADDR_W-1:0] sp,
  output logic [ADDR_W-1:0] access_addr
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  // pre-decrement for writes, current pointer for reads
  function automatic logic [ADDR_W-1:0] ptr_down(input logic [ADDR_W-1:0] p);
    return p - ONE;
  endfunction

  function automatic logic [ADDR_W-1:0] ptr_up(input logic [ADDR_W-1:0] p);
    return p + ONE;
  endfunction

  assign access_addr = step_dn ? ptr_down(sp) : sp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sp <= ADDR_W'(RESET_SP);
    else if (step_dn) sp <= ptr_down(sp);
    else if (step_up) sp <= ptr_up(sp);
  end

endmodule

// File: rtl/stk_word.sv
module stk_word #(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] din,
  input  logic              sel_hi,
  output logic [BYTE_W-1:0] wbyte,
  input  logic              cap_lo,
  input  logic              cap_hi,
  input  logic [BYTE_W-1:0] rbyte,
  output logic [WORD_W-1:0] dout
);

  logic [WORD_W-1:0] held;
  logic [BYTE_W-1:0] lo_q;

  assign wbyte = sel_hi ? held[WORD_W-1:BYTE_W] : held[BYTE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= '0;
      lo_q <= '0;
      dout <= '0;
    end else begin
      if (load)   held <= din;
      if (cap_lo) lo_q <= rbyte;
      if (cap_hi) dout <= {rbyte, lo_q};
    end
  end

endmodule

// File: rtl/stack_seq.sv
module stack_seq #(
  parameter int          ADDR_W   = 16,
  parameter int          BYTE_W   = 8,
  parameter int          COST_W   = 5,
  parameter int unsigned RESET_SP = 'hFFFE
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [1:0]            cmd,
  input  logic                  zero_flag,
  input  logic [2*BYTE_W-1:0]   push_word,
  output logic                  busy,
  output logic                  done,
  output logic                  pc_load,
  output logic [2*BYTE_W-1:0]   pop_word,
  output logic [COST_W-1:0]     cost_ticks,
  output logic [ADDR_W-1:0]     sp_out,
  output logic                  mem_rd,
  output logic                  mem_wr,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [BYTE_W-1:0]     mem_wdata,
  input  logic [BYTE_W-1:0]     mem_rdata
);

  // named internal events, visible to the bound checker
  logic accept_ev;
  logic sp_step_dn;
  logic sp_step_up;
  logic sel_hi;
  logic cap_lo;
  logic cap_hi;

  stk_ctrl #(.COST_W(COST_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cmd        (cmd),
    .zero_flag  (zero_flag),
    .accept     (accept_ev),
    .busy       (busy),
    .step_dn    (sp_step_dn),
    .step_up    (sp_step_up),
    .sel_hi     (sel_hi),
    .cap_lo     (cap_lo),
    .cap_hi     (cap_hi),
    .fin        (done),
    .pc_load    (pc_load),
    .cost_ticks (cost_ticks)
  );

  stk_ptr #(.ADDR_W(ADDR_W), .RESET_SP(RESET_SP)) u_ptr (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_dn     (sp_step_dn),
    .step_up     (sp_step_up),
    .sp          (sp_out),
    .access_addr (mem_addr)
  );

  stk_word #(.BYTE_W(BYTE_W)) u_word (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept_ev),
    .din    (push_word),
    .sel_hi (sel_hi),
    .wbyte  (mem_wdata),
    .cap_lo (cap_lo),
    .cap_hi (cap_hi),
    .rbyte  (mem_rdata),
    .dout   (pop_word)
  );

  assign mem_wr = sp_step_dn;
  assign mem_rd = sp_step_up;

endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int COST_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [1:0]        cmd,
  input logic              busy,
  input logic              done,
  input logic              pc_load,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [ADDR_W-1:0] sp_out,
  input logic [COST_W-1:0] cost_ticks,
  input logic              accept_ev
);

  AST_SP_DOWN_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> sp_out == ADDR_W'($past(sp_out) - ADDR_W'(1))); // R1
  AST_SP_UP_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> sp_out == ADDR_W'($past(sp_out) + ADDR_W'(1))); // R2
  AST_SP_HELD_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd || mem_wr) |=> $stable(sp_out)); // R4
  AST_PCLOAD_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> done); // R5
  AST_COST_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cost_ticks == 8 || cost_ticks == 12 || cost_ticks == 16 || cost_ticks == 20)); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_NO_MEM_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(mem_rd || mem_wr)); // R8
  AST_ACCEPT_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |-> !busy); // R8
  AST_RSVD_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && cmd == 2'b11) |=> !busy); // R10
  AST_RD_WR_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R2

endmodule

bind stack_seq stack_seq_chk #(.ADDR_W(ADDR_W), .COST_W(COST_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .cmd        (cmd),
  .busy       (busy),
  .done       (done),
  .pc_load    (pc_load),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr),
  .sp_out     (sp_out),
  .cost_ticks (cost_ticks),
  .accept_ev  (accept_ev)
);

// File: tb/tb_stack_seq.sv
`timescale 1ns/1ps
module tb_stack_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  cmd = 2'b00;
  logic        zero_flag = 1'b0;
  logic [15:0] push_word = 16'h0;
  logic        busy, done, pc_load;
  logic [15:0] pop_word, sp_out, mem_addr;
  logic [4:0]  cost_ticks;
  logic        mem_rd, mem_wr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'h00;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  stack_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .zero_flag(zero_flag),
    .push_word(push_word), .busy(busy), .done(done), .pc_load(pc_load),
    .pop_word(pop_word), .cost_ticks(cost_ticks), .sp_out(sp_out),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // environment memory: one-cycle read
  logic [7:0] env_mem [int];
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= env_mem.exists(int'(mem_addr)) ? env_mem[int'(mem_addr)] : 8'h00;
    if (mem_wr) env_mem[int'(mem_addr)] = mem_wdata;
  end

  // reference model state
  logic [7:0] ref_mem [int];
  int         ref_sp = 'hFFFE;

  function automatic logic [7:0] ref_get(input int a);
    return ref_mem.exists(a & 'hFFFF) ? ref_mem[a & 'hFFFF] : 8'h00;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // issue one command, then compare every cycle against the model
  task automatic run(input string req, input logic [1:0] c, input logic [15:0] w,
                     input logic z, input bit hold);
    int   n;
    int   s0;
    bit   erd [4];
    bit   ewr [4];
    int   ead [4];
    logic [7:0]  ewd [4];
    logic [15:0] eword;
    int   ecost;
    bit   epc;
    bit   popping;
    s0 = ref_sp;
    for (int i = 0; i < 4; i++) begin erd[i] = 0; ewr[i] = 0; ead[i] = 0; ewd[i] = 0; end
    eword = 0; epc = 0; popping = 0;
    if (c == 2'b00) begin
      n = 3; ecost = 16;
      ewr[0] = 1; ead[0] = (s0 - 1) & 'hFFFF; ewd[0] = w[15:8];
      ewr[1] = 1; ead[1] = (s0 - 2) & 'hFFFF; ewd[1] = w[7:0];
      ref_mem[ead[0]] = w[15:8];
      ref_mem[ead[1]] = w[7:0];
      ref_sp = (s0 - 2) & 'hFFFF;
    end else if (c == 2'b10 && z) begin
      n = 1; ecost = 8;
    end else begin
      n = 4; popping = 1;
      ecost = (c == 2'b10) ? 20 : 12;
      epc = (c == 2'b10);
      erd[0] = 1; ead[0] = s0;
      erd[1] = 1; ead[1] = (s0 + 1) & 'hFFFF;
      eword = {ref_get(s0 + 1), ref_get(s0)};
      ref_sp = (s0 + 2) & 'hFFFF;
    end

    @(negedge clk);
    start = 1'b1; cmd = c; push_word = w; zero_flag = z;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (hold) begin
        cmd = ~c; push_word = ~w; zero_flag = ~z;
      end else begin
        start = 1'b0;
      end
      chk(req, "busy", busy, 1);
      chk(req, "mem_rd", mem_rd, erd[i]);
      chk(req, "mem_wr", mem_wr, ewr[i]);
      if (erd[i] || ewr[i]) chk(req, "mem_addr", mem_addr, ead[i]);
      if (ewr[i]) chk(req, "mem_wdata", mem_wdata, ewd[i]);
      chk("R7", "done", done, (i == n - 1));
      chk(req, "pc_load", pc_load, (i == n - 1) ? epc : 1'b0);
      if (i == n - 1) begin
        chk(req, "cost", cost_ticks, ecost);
        chk(req, "sp", sp_out, ref_sp);
        if (popping) chk(req, "pop_word", pop_word, eword);
      end
    end
    start = 1'b0;
    @(negedge clk);
    chk("R7", "done after pulse", done, 0);
    chk("R8", "busy after done", busy, 0);
    chk("R8", "no mem when idle", mem_rd | mem_wr, 0);
    chk(req, "sp held", sp_out, ref_sp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", "busy", busy, 0);
    chk("R9", "done", done, 0);
    chk("R9", "pc_load", pc_load, 0);
    chk("R9", "mem req", mem_rd | mem_wr, 0);
    chk("R9", "sp", sp_out, 16'hFFFE);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "sp after release", sp_out, 16'hFFFE);

    // R3 wrap upward: pop from 0xFFFE ends at 0x0000
    run("R3", 2'b01, 16'h0, 1'b0, 0);
    // R3 wrap downward: push from 0x0000 writes 0xFFFF, 0xFFFE
    run("R3", 2'b00, 16'hA55A, 1'b0, 0);
    // R1 / R6 push patterns
    run("R1", 2'b00, 16'h1234, 1'b0, 0);
    run("R1", 2'b00, 16'hFF00, 1'b0, 0);
    // R2 / R6 pops in LIFO order
    run("R2", 2'b01, 16'h0, 1'b0, 0);
    run("R2", 2'b01, 16'h0, 1'b0, 0);
    // R4 return not taken
    run("R1", 2'b00, 16'hBEEF, 1'b0, 0);
    run("R4", 2'b10, 16'h0, 1'b1, 0);
    // R5 return taken
    run("R5", 2'b10, 16'h0, 1'b0, 0);
    // R8 start held and inputs changed while busy
    run("R8", 2'b00, 16'hC3E1, 1'b0, 1);
    run("R8", 2'b01, 16'h0, 1'b1, 1);
    // R10 reserved code ignored
    @(negedge clk);
    start = 1'b1; cmd = 2'b11;
    @(negedge clk);
    start = 1'b0;
    chk("R10", "busy", busy, 0);
    chk("R10", "mem req", mem_rd | mem_wr, 0);
    @(negedge clk);
    chk("R10", "busy later", busy, 0);
    chk("R10", "sp", sp_out, ref_sp);
    // R6 more costs: pop of the earlier word
    run("R6", 2'b01, 16'h0, 1'b0, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule